// File: doc/BRIEF.md
# Reset Cause Controller

This block collects reset requests from every source on the chip and turns each accepted request into one fixed-length, active-high system reset pulse. The sources are an external pin, a CPU system-reset request, a debugger request, a watchdog request and a brown-out-high detector, plus two software resets. Each software reset starts only when its own 8-bit key value is written. The analog detectors are outside the block; their decisions arrive as single-bit inputs sampled on the clock.

Every accepted request sets its own bit in a sticky cause register, and a software write clears that register. The cause register and the enable configuration sit in a domain that only the power-on input resets, so software can read after any other reset what caused it. The block also holds a level-controlled reset for a trace port. It handles one brown-out-high interrupt with enable, status, set-on-write and clear-on-write registers. Software reaches all of this through a simple 32-bit register bus. Reads are combinational and writes take effect on the clock edge.

Top module: `rst_cause_ctrl`

## Requirements
- R1: Reads are combinational from `busAddr`. Configuration reads at 0x000 in bits [1:0]. The cause register reads at 0x00C in bits [6:0]. The trace-port reset reads at 0x014 bit 0, the interrupt enable at 0x200 bit 0 and the interrupt status at 0x204 bit 0. Every other address, including the key, clear-cause, interrupt-clear (0x208) and interrupt-set (0x20C) registers, reads 0, and so do all unused bits.
- R2: A write to 0x004 with bits [7:0] equal to 0x1B starts a reset and sets cause bit 4.
- R3: A write to 0x008 with bits [7:0] equal to 0xD4 starts a reset and sets cause bit 3. A CPU system-reset request (`sysReq`) has the same effect.
- R4: A write to 0x004 or 0x008 whose bits [7:0] differ from that register's key starts no reset and leaves the cause register unchanged.
- R5: Cause bits are sticky. The external pin sets bit 0, an accepted brown-out request bit 2, the debugger bit 5 and an accepted watchdog request bit 6. When several sources request in the same cycle, every one of them is recorded.
- R6: A write to 0x010 with bit 0 set clears all cause bits. A cause that arrives in the same cycle is still recorded.
- R7: Configuration bit 0 enables brown-out reset and bit 1 enables watchdog reset. While its enable is 0, such a request neither starts a reset nor sets its cause bit.
- R8: `sysRst` rises in the cycle after an accepted request and stays high for exactly 16 cycles. Requests that arrive during the pulse are recorded but do not extend it.
- R9: While `porIn` is high, the cause register reads 0x02 and configuration, trace-port reset, interrupt enable and interrupt status read 0. `sysRst` is high during that time and for 16 cycles after `porIn` falls.
- R10: `tpRst` follows bit 0 of the last write to 0x014 and holds that value until the next write to that address.
- R11: The interrupt status bit is set by `borReq` (regardless of configuration) or by writing 1 to 0x20C bit 0. Writing 1 to 0x208 bit 0 clears it, and a set wins over a clear in the same cycle. `irqOut` equals the status bit ANDed with the enable bit.
- R12: The cause and configuration registers keep their values through the system reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porIn | input | 1 | Power-on reset, active high, asynchronous; the only reset of the block |
| extReq | input | 1 | External reset pin request |
| borReq | input | 1 | Brown-out-high detected |
| wdtReq | input | 1 | Watchdog reset request |
| dbgReq | input | 1 | Debugger reset request |
| sysReq | input | 1 | CPU system-reset request |
| busAddr | input | 12 | Register byte address |
| busWe | input | 1 | Write strobe, one write per cycle |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for `busAddr` |
| sysRst | output | 1 | System reset pulse, active high |
| tpRst | output | 1 | Trace-port reset level |
| irqOut | output | 1 | Brown-out-high interrupt |

## Verification
The assertions assume that every request input is synchronous and is sampled only at the rising clock edge. They also assume that `porIn` is the only reset and that a bus write lasts exactly the one cycle in which `busWe` is high. The key, clear and gating properties trigger only in cycles where no other request is present. The stimulus therefore drives requests at low random rates, so such quiet cycles occur often, and it biases key-register writes toward the correct key so that both accepted and rejected keys appear. All inputs change on the falling edge, away from the sampling edge. Power-on is applied only in the directed opening sequence.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int ADDR_W    = 12;
  localparam int NUM_CAUSE = 7;

  localparam logic [ADDR_W-1:0] OFF_CFG  = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_POI  = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_POR  = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_STAT = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_CLR  = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_TP   = 12'h014;
  localparam logic [ADDR_W-1:0] OFF_IE   = 12'h200;
  localparam logic [ADDR_W-1:0] OFF_IS   = 12'h204;
  localparam logic [ADDR_W-1:0] OFF_IC   = 12'h208;
  localparam logic [ADDR_W-1:0] OFF_ISET = 12'h20C;

  localparam logic [7:0] KEY_POI = 8'h1B;
  localparam logic [7:0] KEY_POR = 8'hD4;

  // cause bit positions, read by software
  localparam int ST_EXT = 0;
  localparam int ST_PON = 1;
  localparam int ST_BOR = 2;
  localparam int ST_SWR = 3;
  localparam int ST_POI = 4;
  localparam int ST_DBG = 5;
  localparam int ST_WDT = 6;

  typedef struct packed {
    logic cfgWr;
    logic clrStat;
    logic tpWr;
    logic ieWr;
    logic intClr;
    logic intSet;
    logic poiHit;
    logic porHit;
  } rcc_strobe_t;
endpackage

// File: rtl/rcc_ctrl.sv
module rcc_ctrl import rcc_pkg::*; #(
  parameter int PULSE_LEN = 16
) (
  input  logic                 clk,
  input  logic                 porIn,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWe,
  input  logic [7:0]           keyByte,
  input  logic [NUM_CAUSE-1:0] causeVec,
  output rcc_strobe_t          stb,
  output logic                 sysRst
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0] pulseCnt;

  // write decode into strobes for the datapath
  always_comb begin
    stb         = '0;
    stb.cfgWr   = busWe && (busAddr == OFF_CFG);
    stb.clrStat = busWe && (busAddr == OFF_CLR) && keyByte[0];
    stb.tpWr    = busWe && (busAddr == OFF_TP);
    stb.ieWr    = busWe && (busAddr == OFF_IE);
    stb.intClr  = busWe && (busAddr == OFF_IC) && keyByte[0];
    stb.intSet  = busWe && (busAddr == OFF_ISET) && keyByte[0];
    stb.poiHit  = busWe && (busAddr == OFF_POI) && (keyByte == KEY_POI);
    stb.porHit  = busWe && (busAddr == OFF_POR) && (keyByte == KEY_POR);
  end

  // fixed-length pulse; not retriggered while running
  always_ff @(posedge clk or posedge porIn) begin
    if (porIn) begin
      pulseCnt <= CNT_W'(PULSE_LEN);
    end else if (pulseCnt == '0) begin
      if (|causeVec) pulseCnt <= CNT_W'(PULSE_LEN);
    end else begin
      pulseCnt <= pulseCnt - CNT_W'(1);
    end
  end

  assign sysRst = (pulseCnt != '0);
endmodule

// File: rtl/rcc_dp.sv
module rcc_dp import rcc_pkg::*; #(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 porIn,
  input  rcc_strobe_t          stb,
  input  logic [1:0]           wrBits,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 extReq,
  input  logic                 borReq,
  input  logic                 wdtReq,
  input  logic                 dbgReq,
  input  logic                 sysReq,
  output logic [NUM_CAUSE-1:0] causeVec,
  output logic [NUM_CAUSE-1:0] statVec,
  output logic [1:0]           cfgVec,
  output logic                 intStat,
  output logic [DATA_W-1:0]    busRdata,
  output logic                 tpRst,
  output logic                 irqOut
);
  logic intEn;

  // accepted causes this cycle
  always_comb begin
    causeVec         = '0;
    causeVec[ST_EXT] = extReq;
    causeVec[ST_BOR] = borReq && cfgVec[0];
    causeVec[ST_SWR] = sysReq || stb.porHit;
    causeVec[ST_POI] = stb.poiHit;
    causeVec[ST_DBG] = dbgReq;
    causeVec[ST_WDT] = wdtReq && cfgVec[1];
  end

  // sticky cause bits, power-on domain only
  for (genvar i = 0; i < NUM_CAUSE; i++) begin : g_cause
    always_ff @(posedge clk or posedge porIn) begin
      if (porIn)              statVec[i] <= 1'(i == ST_PON);
      else if (stb.clrStat)   statVec[i] <= causeVec[i];
      else if (causeVec[i])   statVec[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk or posedge porIn) begin
    if (porIn) begin
      cfgVec  <= '0;
      tpRst   <= 1'b0;
      intEn   <= 1'b0;
      intStat <= 1'b0;
    end else begin
      if (stb.cfgWr) cfgVec <= wrBits;
      if (stb.tpWr)  tpRst  <= wrBits[0];
      if (stb.ieWr)  intEn  <= wrBits[0];
      if (borReq || stb.intSet) intStat <= 1'b1;
      else if (stb.intClr)      intStat <= 1'b0;
    end
  end

  assign irqOut = intStat && intEn;

  always_comb begin
    busRdata = '0;
    case (busAddr)
      OFF_CFG:  busRdata[1:0]           = cfgVec;
      OFF_STAT: busRdata[NUM_CAUSE-1:0] = statVec;
      OFF_TP:   busRdata[0]             = tpRst;
      OFF_IE:   busRdata[0]             = intEn;
      OFF_IS:   busRdata[0]             = intStat;
      default:  busRdata                = '0;
    endcase
  end
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl import rcc_pkg::*; #(
  parameter int DATA_W    = 32,
  parameter int PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              porIn,
  input  logic              extReq,
  input  logic              borReq,
  input  logic              wdtReq,
  input  logic              dbgReq,
  input  logic              sysReq,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              sysRst,
  output logic              tpRst,
  output logic              irqOut
);
  rcc_strobe_t          stb;
  logic [NUM_CAUSE-1:0] causeVec;
  logic [NUM_CAUSE-1:0] statVec;
  logic [1:0]           cfgVec;
  logic                 intStat;
  logic                 unusedWdata;

  assign unusedWdata = ^busWdata[DATA_W-1:8];

  rcc_ctrl #(.PULSE_LEN(PULSE_LEN)) ctrl_i (
    .clk(clk), .porIn(porIn), .busAddr(busAddr), .busWe(busWe),
    .keyByte(busWdata[7:0]), .causeVec(causeVec), .stb(stb), .sysRst(sysRst)
  );

  rcc_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .porIn(porIn), .stb(stb), .wrBits(busWdata[1:0]),
    .busAddr(busAddr), .extReq(extReq), .borReq(borReq), .wdtReq(wdtReq),
    .dbgReq(dbgReq), .sysReq(sysReq), .causeVec(causeVec), .statVec(statVec),
    .cfgVec(cfgVec), .intStat(intStat), .busRdata(busRdata), .tpRst(tpRst),
    .irqOut(irqOut)
  );
endmodule

// File: rtl/rcc_checker.sv
module rcc_checker import rcc_pkg::*; #(
  parameter int PULSE_LEN = 16
) (
  input logic                 clk,
  input logic                 porIn,
  input logic                 extReq,
  input logic                 borReq,
  input logic                 wdtReq,
  input logic                 dbgReq,
  input logic                 sysReq,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 busWe,
  input logic [7:0]           keyByte,
  input logic                 sysRst,
  input logic                 tpRst,
  input logic                 irqOut,
  input logic [NUM_CAUSE-1:0] statVec,
  input logic [1:0]           cfgVec,
  input logic                 intStat
);
  localparam int RUN_W = $clog2(PULSE_LEN + 2) + 1;

  logic [RUN_W-1:0] runLen;
  logic             noReq;

  assign noReq = !extReq && !borReq && !wdtReq && !dbgReq && !sysReq;

  // length of the current high stretch of sysRst
  always_ff @(posedge clk or posedge porIn) begin
    if (porIn)       runLen <= '0;
    else if (sysRst) runLen <= runLen + RUN_W'(1);
    else             runLen <= '0;
  end

  a_r8_pulse_len: assert property (@(posedge clk) disable iff (porIn)
    $fell(sysRst) |-> runLen == RUN_W'(PULSE_LEN));

  a_r8_no_extend: assert property (@(posedge clk) disable iff (porIn)
    runLen <= RUN_W'(PULSE_LEN));

  a_r2_poi_cause: assert property (@(posedge clk) disable iff (porIn)
    (busWe && busAddr == OFF_POI && keyByte == KEY_POI) |=> statVec[ST_POI]);

  a_r4_bad_key: assert property (@(posedge clk) disable iff (porIn)
    (busWe && busAddr == OFF_POI && keyByte != KEY_POI && noReq && !sysRst)
      |=> !sysRst);

  a_r6_clear: assert property (@(posedge clk) disable iff (porIn)
    (busWe && busAddr == OFF_CLR && keyByte[0] && noReq) |=> statVec == '0);

  a_r7_wdt_gate: assert property (@(posedge clk) disable iff (porIn)
    (wdtReq && !cfgVec[1] && !busWe)
      |=> statVec[ST_WDT] == $past(statVec[ST_WDT]));

  a_r10_tp_write: assert property (@(posedge clk) disable iff (porIn)
    (busWe && busAddr == OFF_TP) |=> tpRst == $past(keyByte[0]));

  a_r10_tp_hold: assert property (@(posedge clk) disable iff (porIn)
    !(busWe && busAddr == OFF_TP) |=> $stable(tpRst));

  a_r11_bor_int: assert property (@(posedge clk) disable iff (porIn)
    borReq |=> intStat);

  a_r11_mask: assert property (@(posedge clk) disable iff (porIn)
    (busWe && busAddr == OFF_IE && !keyByte[0]) |=> !irqOut);

  a_r12_sticky: assert property (@(posedge clk) disable iff (porIn)
    (sysRst && !busWe && noReq) |=> statVec == $past(statVec));
endmodule

bind rst_cause_ctrl rcc_checker #(.PULSE_LEN(PULSE_LEN)) chk_i (
  .clk(clk), .porIn(porIn), .extReq(extReq), .borReq(borReq),
  .wdtReq(wdtReq), .dbgReq(dbgReq), .sysReq(sysReq), .busAddr(busAddr),
  .busWe(busWe), .keyByte(busWdata[7:0]), .sysRst(sysRst), .tpRst(tpRst),
  .irqOut(irqOut), .statVec(statVec), .cfgVec(cfgVec), .intStat(intStat)
);

// File: tb/rst_cause_ctrl_tb_top.sv
module rst_cause_ctrl_tb_top;
  import rcc_pkg::*;

  localparam int CLK_P     = 10;
  localparam int DATA_W    = 32;
  localparam int PULSE_LEN = 16;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic porIn, extReq, borReq, wdtReq, dbgReq, sysReq, busWe;
  logic [ADDR_W-1:0] busAddr;
  logic [DATA_W-1:0] busWdata, busRdata;
  logic sysRst, tpRst, irqOut;

  int checks = 0;
  int failures = 0;

  // bench model
  logic [1:0] mCfg;
  logic [6:0] mStat;
  logic mTp, mIe, mIs;
  int mCnt;

  rst_cause_ctrl #(.DATA_W(DATA_W), .PULSE_LEN(PULSE_LEN)) dut_i (
    .clk(clk), .porIn(porIn), .extReq(extReq), .borReq(borReq),
    .wdtReq(wdtReq), .dbgReq(dbgReq), .sysReq(sysReq), .busAddr(busAddr),
    .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata),
    .sysRst(sysRst), .tpRst(tpRst), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] modelRead(input logic [ADDR_W-1:0] a);
    case (a)
      OFF_CFG:  return {30'd0, mCfg};
      OFF_STAT: return {25'd0, mStat};
      OFF_TP:   return {31'd0, mTp};
      OFF_IE:   return {31'd0, mIe};
      OFF_IS:   return {31'd0, mIs};
      default:  return 32'd0;
    endcase
  endfunction

  function automatic string tagOf(input logic [ADDR_W-1:0] a);
    case (a)
      OFF_CFG:          return "R7";
      OFF_STAT:         return "R5";
      OFF_TP:           return "R10";
      OFF_IE, OFF_IS:   return "R11";
      OFF_POI, OFF_POR: return "R4";
      default:          return "R1";
    endcase
  endfunction

  task automatic modelReset();
    mCfg = 2'b00; mStat = 7'h02; mTp = 1'b0; mIe = 1'b0; mIs = 1'b0;
    mCnt = PULSE_LEN;
  endtask

  task automatic modelUpdate(input logic [ADDR_W-1:0] a, input logic we,
                             input logic [31:0] d, input logic ex, bo, wd, db, sy);
    logic [6:0] acc;
    acc = '0;
    acc[0] = ex;
    acc[2] = bo && mCfg[0];
    acc[3] = sy || (we && a == OFF_POR && d[7:0] == 8'hD4);
    acc[4] = we && a == OFF_POI && d[7:0] == 8'h1B;
    acc[5] = db;
    acc[6] = wd && mCfg[1];
    if (we && a == OFF_CLR && d[0]) mStat = acc;
    else mStat = mStat | acc;
    if (mCnt == 0) begin
      if (acc != 0) mCnt = PULSE_LEN;
    end else mCnt = mCnt - 1;
    if (we && a == OFF_CFG) mCfg = d[1:0];
    if (we && a == OFF_TP)  mTp = d[0];
    if (we && a == OFF_IE)  mIe = d[0];
    if (bo || (we && a == OFF_ISET && d[0])) mIs = 1'b1;
    else if (we && a == OFF_IC && d[0]) mIs = 1'b0;
  endtask

  // one cycle: drive at negedge, check read before edge, outputs after edge
  task automatic step(input logic [ADDR_W-1:0] a, input logic we, input logic [31:0] d,
                      input logic ex, bo, wd, db, sy);
    busAddr = a; busWe = we; busWdata = d;
    extReq = ex; borReq = bo; wdtReq = wd; dbgReq = db; sysReq = sy;
    #(CLK_P/4);
    chk(tagOf(a), busRdata, modelRead(a));
    @(posedge clk);
    modelUpdate(a, we, d, ex, bo, wd, db, sy);
    @(negedge clk);
    chk("R8", {31'd0, sysRst}, {31'd0, mCnt != 0});
    chk("R10", {31'd0, tpRst}, {31'd0, mTp});
    chk("R11", {31'd0, irqOut}, {31'd0, mIs && mIe});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(OFF_STAT, 1'b0, 32'd0, 0, 0, 0, 0, 0);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    step(a, 1'b1, d, 0, 0, 0, 0, 0);
  endtask

  task automatic waitQuiet();
    while (sysRst) idle(1);
  endtask

  function automatic logic [31:0] rd(input logic [ADDR_W-1:0] a);
    busAddr = a; busWe = 1'b0;
    return busRdata;
  endfunction

  task automatic rdChk(input string tag, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
    void'(rd(a));
    #1;
    chk(tag, busRdata, exp);
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++; failures++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] addrs [11];
    int n;
    int seedDummy;
    addrs = '{OFF_CFG, OFF_POI, OFF_POR, OFF_STAT, OFF_CLR, OFF_TP,
              OFF_IE, OFF_IS, OFF_IC, OFF_ISET, 12'h018};
    seedDummy = $urandom(32'd20240611);

    // R9: power-on
    porIn = 1'b1; busWe = 0; busAddr = OFF_STAT; busWdata = 0;
    extReq = 0; borReq = 0; wdtReq = 0; dbgReq = 0; sysReq = 0;
    modelReset();
    repeat (3) @(negedge clk);
    chk("R9", {31'd0, sysRst}, 32'd1);
    rdChk("R9", OFF_STAT, 32'h02);
    rdChk("R9", OFF_CFG, 32'h0);
    rdChk("R9", OFF_IS, 32'h0);
    rdChk("R9", OFF_TP, 32'h0);
    @(negedge clk);
    porIn = 1'b0;
    n = 0;
    while (sysRst) begin idle(1); n++; end
    chk("R9", n, PULSE_LEN);

    // R8: pulse length, no extension by a request during it
    step(OFF_STAT, 0, 0, 1, 0, 0, 0, 0);
    n = sysRst ? 1 : 0;
    for (int i = 0; i < 20; i++) begin
      if (i == 3) step(OFF_STAT, 0, 0, 0, 0, 0, 1, 0);
      else idle(1);
      if (sysRst) n++;
    end
    chk("R8", n, PULSE_LEN);
    rdChk("R5", OFF_STAT, 32'h23);

    // R4: wrong keys
    wr(OFF_POI, 32'h1A);
    chk("R4", {31'd0, sysRst}, 32'd0);
    wr(OFF_POR, 32'h1B);
    chk("R4", {31'd0, sysRst}, 32'd0);
    rdChk("R4", OFF_STAT, 32'h23);
    rdChk("R4", OFF_POI, 32'h0);

    // R6: clear
    wr(OFF_CLR, 32'h1);
    rdChk("R6", OFF_STAT, 32'h0);

    // R2 / R3: keyed software resets
    wr(OFF_POI, 32'hFFFF_FF1B);
    chk("R2", {31'd0, sysRst}, 32'd1);
    rdChk("R2", OFF_STAT, 32'h10);
    waitQuiet();
    wr(OFF_POR, 32'h0000_00D4);
    chk("R3", {31'd0, sysRst}, 32'd1);
    rdChk("R3", OFF_STAT, 32'h18);
    waitQuiet();
    step(OFF_CLR, 1, 32'h1, 1, 0, 0, 0, 0);
    rdChk("R6", OFF_STAT, 32'h01);
    waitQuiet();

    // R5: simultaneous sources
    wr(OFF_CLR, 32'h1);
    step(OFF_STAT, 0, 0, 1, 0, 0, 1, 1);
    rdChk("R5", OFF_STAT, 32'h29);
    waitQuiet();

    // R7: gating by configuration
    wr(OFF_CLR, 32'h1);
    wr(OFF_CFG, 32'h0);
    step(OFF_STAT, 0, 0, 0, 0, 1, 0, 0);
    chk("R7", {31'd0, sysRst}, 32'd0);
    step(OFF_STAT, 0, 0, 0, 1, 0, 0, 0);
    chk("R7", {31'd0, sysRst}, 32'd0);
    rdChk("R7", OFF_STAT, 32'h0);
    rdChk("R11", OFF_IS, 32'h1);
    wr(OFF_CFG, 32'h3);
    step(OFF_STAT, 0, 0, 0, 0, 1, 0, 0);
    chk("R7", {31'd0, sysRst}, 32'd1);
    rdChk("R7", OFF_STAT, 32'h40);
    waitQuiet();
    step(OFF_STAT, 0, 0, 0, 1, 0, 0, 0);
    rdChk("R7", OFF_STAT, 32'h44);
    waitQuiet();
    rdChk("R12", OFF_STAT, 32'h44);
    rdChk("R12", OFF_CFG, 32'h3);

    // R10: trace-port level
    wr(OFF_TP, 32'h1);
    idle(5);
    chk("R10", {31'd0, tpRst}, 32'd1);
    wr(OFF_TP, 32'h0);
    chk("R10", {31'd0, tpRst}, 32'd0);

    // R11: interrupt
    wr(OFF_IC, 32'h1);
    rdChk("R11", OFF_IS, 32'h0);
    wr(OFF_IE, 32'h1);
    wr(OFF_ISET, 32'h1);
    chk("R11", {31'd0, irqOut}, 32'd1);
    step(OFF_IC, 1, 32'h1, 0, 1, 0, 0, 0);
    chk("R11", {31'd0, irqOut}, 32'd1);
    waitQuiet();
    wr(OFF_IC, 32'h1);
    chk("R11", {31'd0, irqOut}, 32'd0);

    // R1: unmapped and write-only addresses read zero
    rdChk("R1", 12'h018, 32'h0);
    rdChk("R1", OFF_CLR, 32'h0);
    rdChk("R1", OFF_IC, 32'h0);
    rdChk("R1", OFF_CFG, 32'h3);

    // random mix against the model
    for (int i = 0; i < 3000; i++) begin
      logic [ADDR_W-1:0] a;
      logic [31:0] d;
      logic we;
      a  = addrs[$urandom % 11];
      we = ($urandom % 3) == 0;
      d  = $urandom;
      if (a == OFF_POI && $urandom % 2 == 0) d[7:0] = 8'h1B;
      if (a == OFF_POR && $urandom % 2 == 0) d[7:0] = 8'hD4;
      step(a, we, d, ($urandom % 32) == 0, ($urandom % 16) == 0,
           ($urandom % 16) == 0, ($urandom % 32) == 0, ($urandom % 40) == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule